// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block runs the address and data transfer cycles of an enhanced bidirectional parallel port. It sits behind a simple host request interface. A host access to one of two transfer offsets becomes one or more byte handshakes with the attached peripheral. A transfer starts only when the port's control register holds exactly the pattern the transfer direction needs. An access made under any other pattern touches no peripheral pin and still completes.

Each byte handshake selects a strobe by offset: the address strobe for offset 3 and the data strobe for offset 4. The block then waits for the peripheral's wait line to rise. It releases the strobe and waits for the wait line to fall. Offset 4 also takes 2-byte and 4-byte accesses, which it splits into byte handshakes, least significant byte first.

If the peripheral stops answering, a per-phase cycle limit ends the access and sets a sticky timeout flag. Any remaining bytes of the access are dropped. Software reads the flag in status bit 0 and clears it by writing a one to that bit.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset the control register reads 0x0C, the timeout flag is 0, both strobes and the write line are high (inactive), the data bus is not driven and ready is low.
- R2: Offset 2 is an 8-bit control register that reads back the value last written. A read of offset 1 returns the timeout flag in bit 0 and zero in every other bit.
- R3: A write to offset 3 or 4 runs handshakes only when control bits {5,3,2,1,0} equal exactly 0,0,1,0,0, which means control & 0x2F == 0x04. Under any other control value no strobe falls, and ready is still returned.
- R4: A read of offset 3 or 4 runs handshakes only when control & 0x2F == 0x24. Under any other control value no strobe falls and the read returns 0xFFFFFFFF.
- R5: Offset 3 handshakes use the address strobe and offset 4 handshakes use the data strobe, never both at once. During a write handshake the write line is low and the data bus drives the byte. A strobe stays low until wait is high, and the block then waits for wait to fall.
- R6: During a read handshake the write line stays high. The byte on the data-in bus is captured when wait is seen high, and a byte read returns it zero-extended.
- R7: At offset 4, size code 0 moves 1 byte, code 1 moves 2 bytes and code 2 moves 4 bytes, least significant byte first. A read assembles the bytes and zero-extends the result. Offset 3 always moves exactly one byte, whatever the size code.
- R8: If wait does not change within TMO_CYCLES clocks in either phase, the strobe is released, the timeout flag is set and the rest of the access is skipped. Read bytes that were not received return as ones.
- R9: The timeout flag stays set across later successful cycles. Writing offset 1 with bit 0 set clears it. Writing offset 1 with bit 0 clear leaves it unchanged.
- R10: Each accepted request gets exactly one ready pulse, one cycle wide. Register accesses raise ready in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until ready |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register offset |
| size | input | 2 | Access size code (0 byte, 1 two bytes, 2 four bytes) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with ready |
| ready | output | 1 | One-cycle completion pulse |
| pd_out | output | 8 | Peripheral data bus, outbound |
| pd_oe | output | 1 | Output enable for pd_out |
| pd_in | input | 8 | Peripheral data bus, inbound |
| n_write | output | 1 | Write line, low during write handshakes |
| n_dstb | output | 1 | Data strobe, active low |
| n_astb | output | 1 | Address strobe, active low |
| wait_i | input | 1 | Peripheral wait/acknowledge line |

## Verification
The assertions check on every cycle that:
- a strobe or a low write line appears only while the control register matches the write pattern or read pattern for that direction;
- the two strobes are never low together;
- the bus is driven only during write handshakes;
- the phase counter stays within its limit;
- the timeout flag rises only after an expired handshake;
- ready never lasts two cycles.

The byte order of wide transfers, the assembled read values, the all-ones result of gated reads, the skipping of bytes after a timeout and the stickiness and clearing of the flag can only be shown by the bench's scenarios. It shows them against a behavioural peripheral whose response can be delayed or switched off.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int OFS_STATUS   = 1;
  localparam int OFS_CTRL     = 2;
  localparam int OFS_EPP_ADDR = 3;
  localparam int OFS_EPP_DATA = 4;

  localparam logic [7:0] CTRL_GATE_MASK = 8'h2F;
  localparam logic [7:0] CTRL_WR_MATCH  = 8'h04;
  localparam logic [7:0] CTRL_RD_MATCH  = 8'h24;
  localparam logic [7:0] CTRL_RESET     = 8'h0C;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [1:0] {E_IDLE, E_STB, E_REL} eng_state_e;
  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_DONE} seq_state_e;
endpackage

// File: rtl/epp_ctrl_regs.sv
module epp_ctrl_regs
  import epp_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       tmo_set,
  input  logic       tmo_clr,
  output logic [7:0] ctrl_q,
  output logic       tmo_q
);
  logic [7:0] ctrl_d;
  logic       tmo_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_wdata;
    tmo_d = tmo_q;
    if (tmo_set)      tmo_d = 1'b1;
    else if (tmo_clr) tmo_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      tmo_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      tmo_q  <= tmo_d;
    end
  end
endmodule

// File: rtl/epp_byte_engine.sv
module epp_byte_engine
  import epp_gate_pkg::*;
#(
  parameter int TMO_CYCLES = 1000,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_wr,
  input  logic              is_astb,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              wait_i,
  input  logic [BYTE_W-1:0] pd_in,
  output logic              done,
  output logic              timed_out,
  output logic [BYTE_W-1:0] rbyte,
  output logic              n_write,
  output logic              n_dstb,
  output logic              n_astb,
  output logic [BYTE_W-1:0] pd_out,
  output logic              pd_oe
);
  localparam int               CNT_W    = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  eng_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q, astb_q;
  logic [BYTE_W-1:0] wb_q, rb_q, rb_d;
  logic              expired, cap_en;

  assign expired = (cnt_q == CNT_LAST);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    rb_d      = rb_q;
    done      = 1'b0;
    timed_out = 1'b0;
    cap_en    = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (start) begin
          st_d  = E_STB;
          cnt_d = '0;
        end
      end
      E_STB: begin
        if (wait_i) begin
          st_d   = E_REL;
          cnt_d  = '0;
          cap_en = !wr_q;
          rb_d   = pd_in;
        end else if (expired) begin
          st_d      = E_IDLE;
          done      = 1'b1;
          timed_out = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      E_REL: begin
        if (!wait_i) begin
          st_d = E_IDLE;
          done = 1'b1;
        end else if (expired) begin
          st_d      = E_IDLE;
          done      = 1'b1;
          timed_out = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      astb_q <= 1'b0;
      wb_q   <= '0;
      rb_q   <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (start && st_q == E_IDLE) begin
        wr_q   <= is_wr;
        astb_q <= is_astb;
        wb_q   <= wbyte;
      end
      if (cap_en) rb_q <= rb_d;
    end
  end

  assign rbyte   = rb_q;
  assign pd_oe   = (st_q != E_IDLE) && wr_q;
  assign n_write = !pd_oe;
  assign pd_out  = wb_q;
  assign n_dstb  = !((st_q == E_STB) && !astb_q);
  assign n_astb  = !((st_q == E_STB) && astb_q);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!n_dstb && !n_astb)); // R5
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pd_oe |-> !n_write); // R5
  AST_RELEASE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_STB && wait_i) |=> (n_dstb && n_astb)); // R5
  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R8
endmodule

// File: rtl/epp_sequencer.sv
module epp_sequencer
  import epp_gate_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  input  logic [7:0]        ctrl_q,
  input  logic              tmo_q,
  input  logic              eng_done,
  input  logic              eng_to,
  input  logic [BYTE_W-1:0] eng_rbyte,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              eng_start,
  output logic              eng_wr,
  output logic              eng_astb,
  output logic [BYTE_W-1:0] eng_wbyte,
  output logic              ctrl_we,
  output logic [7:0]        ctrl_wdata,
  output logic              tmo_set,
  output logic              tmo_clr
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  seq_state_e        st_q, st_d;
  logic              wr_q, wr_d, astb_q, astb_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d, req_last;
  logic [DATA_W-1:0] wbuf_q, wbuf_d, rbuf_q, rbuf_d, rdata_q, rdata_d;
  logic              is_epp, gate_ok, finish;

  always_comb begin
    is_epp = (addr == ADDR_W'(OFS_EPP_ADDR)) || (addr == ADDR_W'(OFS_EPP_DATA));
    gate_ok = wr ? ((ctrl_q & CTRL_GATE_MASK) == CTRL_WR_MATCH)
                 : ((ctrl_q & CTRL_GATE_MASK) == CTRL_RD_MATCH);
    req_last = '0;
    if (addr == ADDR_W'(OFS_EPP_DATA)) begin
      if (size == SZ_BYTE)      req_last = '0;
      else if (size == SZ_HALF) req_last = IDX_W'(1);
      else                      req_last = IDX_W'(NBYTES - 1);
    end
  end

  always_comb begin
    st_d = st_q;  wr_d = wr_q;  astb_d = astb_q;
    idx_d = idx_q;  last_d = last_q;
    wbuf_d = wbuf_q;  rbuf_d = rbuf_q;  rdata_d = rdata_q;
    ready = 1'b0;  eng_start = 1'b0;  ctrl_we = 1'b0;
    tmo_set = 1'b0;  tmo_clr = 1'b0;  finish = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req) begin
          wr_d   = wr;
          astb_d = (addr == ADDR_W'(OFS_EPP_ADDR));
          idx_d  = '0;
          last_d = req_last;
          wbuf_d = wdata;
          rbuf_d = '1;
          st_d   = S_DONE;
          if (is_epp) begin
            if (gate_ok)  st_d = S_LAUNCH;
            else if (!wr) rdata_d = '1;
          end else if (wr) begin
            ctrl_we = (addr == ADDR_W'(OFS_CTRL));
            tmo_clr = (addr == ADDR_W'(OFS_STATUS)) && wdata[0];
          end else begin
            if (addr == ADDR_W'(OFS_CTRL))        rdata_d = DATA_W'(ctrl_q);
            else if (addr == ADDR_W'(OFS_STATUS)) rdata_d = DATA_W'(tmo_q);
            else                                  rdata_d = '0;
          end
        end
      end
      S_LAUNCH: begin
        eng_start = 1'b1;
        st_d      = S_WAIT;
      end
      S_WAIT: begin
        if (eng_done) begin
          if (!wr_q && !eng_to) begin
            for (int k = 0; k < NBYTES; k++)
              if (IDX_W'(k) == idx_q) rbuf_d[k*BYTE_W +: BYTE_W] = eng_rbyte;
          end
          if (eng_to) begin
            tmo_set = 1'b1;
            finish  = 1'b1;
          end else if (idx_q == last_q) begin
            finish = 1'b1;
          end else begin
            idx_d  = idx_q + 1'b1;
            wbuf_d = wbuf_q >> BYTE_W;
            st_d   = S_LAUNCH;
          end
          if (finish) begin
            st_d = S_DONE;
            if (!wr_q) begin
              for (int k = 0; k < NBYTES; k++)
                rdata_d[k*BYTE_W +: BYTE_W] = (IDX_W'(k) <= last_q) ?
                                              rbuf_d[k*BYTE_W +: BYTE_W] : '0;
            end
          end
        end
      end
      S_DONE: begin
        ready = 1'b1;
        st_d  = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  wr_q <= 1'b0;  astb_q <= 1'b0;
      idx_q <= '0;  last_q <= '0;
      wbuf_q <= '0;  rbuf_q <= '1;  rdata_q <= '0;
    end else begin
      st_q <= st_d;  wr_q <= wr_d;  astb_q <= astb_d;
      idx_q <= idx_d;  last_q <= last_d;
      wbuf_q <= wbuf_d;  rbuf_q <= rbuf_d;  rdata_q <= rdata_d;
    end
  end

  assign rdata      = rdata_q;
  assign eng_wr     = wr_q;
  assign eng_astb   = astb_q;
  assign eng_wbyte  = wbuf_q[BYTE_W-1:0];
  assign ctrl_wdata = wdata[7:0];

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R10
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_gate_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 3,
  parameter int TMO_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic [BYTE_W-1:0] pd_out,
  output logic              pd_oe,
  input  logic [BYTE_W-1:0] pd_in,
  output logic              n_write,
  output logic              n_dstb,
  output logic              n_astb,
  input  logic              wait_i
);
  logic [7:0]        ctrl_q, ctrl_wdata;
  logic              tmo_q, ctrl_we, tmo_set, tmo_clr;
  logic              eng_start, eng_wr, eng_astb, eng_done, eng_to;
  logic [BYTE_W-1:0] eng_wbyte, eng_rbyte;

  epp_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .tmo_set(tmo_set), .tmo_clr(tmo_clr), .ctrl_q(ctrl_q), .tmo_q(tmo_q)
  );

  epp_sequencer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
    .wdata(wdata), .ctrl_q(ctrl_q), .tmo_q(tmo_q), .eng_done(eng_done),
    .eng_to(eng_to), .eng_rbyte(eng_rbyte), .ready(ready), .rdata(rdata),
    .eng_start(eng_start), .eng_wr(eng_wr), .eng_astb(eng_astb),
    .eng_wbyte(eng_wbyte), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .tmo_set(tmo_set), .tmo_clr(tmo_clr)
  );

  epp_byte_engine #(.TMO_CYCLES(TMO_CYCLES), .BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .is_wr(eng_wr),
    .is_astb(eng_astb), .wbyte(eng_wbyte), .wait_i(wait_i), .pd_in(pd_in),
    .done(eng_done), .timed_out(eng_to), .rbyte(eng_rbyte),
    .n_write(n_write), .n_dstb(n_dstb), .n_astb(n_astb),
    .pd_out(pd_out), .pd_oe(pd_oe)
  );

  AST_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !n_write |-> ((ctrl_q & CTRL_GATE_MASK) == CTRL_WR_MATCH)); // R3
  AST_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!n_dstb || !n_astb) && n_write) |-> ((ctrl_q & CTRL_GATE_MASK) == CTRL_RD_MATCH)); // R4
  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(eng_to)); // R8
endmodule

// File: tb/epp_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_tb;
  localparam int TMO = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0, rdata;
  logic        ready, pd_oe, n_write, n_dstb, n_astb;
  logic [7:0]  pd_out;
  logic [7:0]  pd_in;
  logic        wait_i;

  int total = 0, bad = 0;
  logic finished = 1'b0;
  logic resp_en = 1'b1;
  int   p_dly = 2;

  always #4 clk = ~clk;

  epp_cycle_ctrl #(.TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .size(size),
    .wdata(wdata), .rdata(rdata), .ready(ready), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .n_write(n_write), .n_dstb(n_dstb), .n_astb(n_astb),
    .wait_i(wait_i)
  );

  // behavioural peripheral
  int         p_bytes, p_stb, dcnt;
  logic       stb_prev;
  logic [7:0] log_data [64];
  logic       log_astb [64];
  logic       log_nw   [64];
  wire        stb_low = !n_dstb || !n_astb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_i <= 1'b0; pd_in <= 8'h00; p_bytes <= 0; p_stb <= 0;
      dcnt <= 0; stb_prev <= 1'b0;
    end else begin
      stb_prev <= stb_low;
      if (stb_low && !stb_prev) p_stb <= p_stb + 1;
      if (!resp_en) begin
        wait_i <= 1'b0; dcnt <= 0;
      end else if (!wait_i && stb_low) begin
        if (dcnt >= p_dly) begin
          wait_i <= 1'b1; dcnt <= 0;
          pd_in <= 8'h30 + 8'(p_bytes);
          log_data[p_bytes % 64] <= pd_out;
          log_astb[p_bytes % 64] <= !n_astb;
          log_nw[p_bytes % 64]   <= n_write;
          p_bytes <= p_bytes + 1;
        end else dcnt <= dcnt + 1;
      end else if (wait_i && !stb_low) begin
        if (dcnt >= p_dly) begin wait_i <= 1'b0; dcnt <= 0; end
        else dcnt <= dcnt + 1;
      end else dcnt <= 0;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [2:0] a, input logic [1:0] sz,
                     input logic [31:0] d, output logic [31:0] q, output int cyc);
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; size = sz; wdata = d; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!ready && cyc < 5000);
    q = rdata; req = 1'b0;
    @(negedge clk);
    chk("R10", "ready single pulse", 32'(ready), 32'd0);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] q; int c;
    bus(1'b1, a, 2'd0, d, q, c);
  endtask

  task automatic t_reset;
    logic [31:0] q; int c;
    chk("R1", "n_write", 32'(n_write), 32'd1);
    chk("R1", "strobes", {30'd0, n_dstb, n_astb}, 32'd3);
    chk("R1", "pd_oe", 32'(pd_oe), 32'd0);
    chk("R1", "ready", 32'(ready), 32'd0);
    bus(1'b0, 3'd2, 2'd0, 0, q, c);
    chk("R1", "control reset", q, 32'h0C);
    chk("R10", "reg access latency", 32'(c), 32'd1);
    bus(1'b0, 3'd1, 2'd0, 0, q, c);
    chk("R1", "flag reset", q, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] q; int c;
    wreg(3'd2, 32'hA5);
    bus(1'b0, 3'd2, 2'd0, 0, q, c);
    chk("R2", "control readback", q, 32'hA5);
  endtask

  task automatic t_wr_gate;
    int s;
    s = p_stb;
    wreg(3'd2, 32'h0C);
    wreg(3'd4, 32'h12);
    wreg(3'd2, 32'h05);
    wreg(3'd3, 32'h13);
    wreg(3'd2, 32'h24);
    wreg(3'd4, 32'h14);
    chk("R3", "no strobe when gated", 32'(p_stb - s), 32'd0);
  endtask

  task automatic t_writes;
    logic [31:0] q; int c, s;
    wreg(3'd2, 32'h04);
    s = p_bytes;
    wreg(3'd4, 32'h5C);
    chk("R3", "byte write ran", 32'(p_bytes - s), 32'd1);
    chk("R5", "data byte", 32'(log_data[s % 64]), 32'h5C);
    chk("R5", "data strobe used", 32'(log_astb[s % 64]), 32'd0);
    chk("R5", "write line low", 32'(log_nw[s % 64]), 32'd0);
    s = p_bytes;
    wreg(3'd3, 32'h71);
    chk("R5", "addr strobe used", 32'(log_astb[s % 64]), 32'd1);
    chk("R5", "addr byte", 32'(log_data[s % 64]), 32'h71);
    chk("R5", "bus released", 32'(pd_oe), 32'd0);
    s = p_bytes;
    bus(1'b1, 3'd4, 2'd2, 32'h44332211, q, c);
    chk("R7", "word byte count", 32'(p_bytes - s), 32'd4);
    chk("R7", "word byte order", {log_data[(s+3)%64], log_data[(s+2)%64],
        log_data[(s+1)%64], log_data[s%64]}, 32'h44332211);
    s = p_bytes;
    bus(1'b1, 3'd4, 2'd1, 32'h0000BEEF, q, c);
    chk("R7", "half byte count", 32'(p_bytes - s), 32'd2);
    chk("R7", "half byte order", {16'd0, log_data[(s+1)%64], log_data[s%64]}, 32'h0000BEEF);
    s = p_bytes;
    bus(1'b1, 3'd3, 2'd2, 32'h99887766, q, c);
    chk("R7", "offset 3 single byte", 32'(p_bytes - s), 32'd1);
    chk("R7", "offset 3 low byte", 32'(log_data[s % 64]), 32'h66);
  endtask

  task automatic t_rd_gate;
    logic [31:0] q; int c, s;
    wreg(3'd2, 32'h04);
    s = p_stb;
    bus(1'b0, 3'd4, 2'd2, 0, q, c);
    chk("R4", "gated wide read", q, 32'hFFFFFFFF);
    bus(1'b0, 3'd3, 2'd0, 0, q, c);
    chk("R4", "gated byte read", q, 32'hFFFFFFFF);
    chk("R4", "no strobe when gated", 32'(p_stb - s), 32'd0);
  endtask

  task automatic t_reads;
    logic [31:0] q, e; int c, s;
    wreg(3'd2, 32'h24);
    s = p_bytes;
    bus(1'b0, 3'd4, 2'd0, 0, q, c);
    chk("R6", "byte read", q, {24'd0, 8'h30 + 8'(s)});
    chk("R6", "write line high", 32'(log_nw[s % 64]), 32'd1);
    s = p_bytes;
    bus(1'b0, 3'd4, 2'd2, 0, q, c);
    e = {8'h30 + 8'(s+3), 8'h30 + 8'(s+2), 8'h30 + 8'(s+1), 8'h30 + 8'(s)};
    chk("R7", "word read assembled", q, e);
    s = p_bytes;
    bus(1'b0, 3'd4, 2'd1, 0, q, c);
    chk("R7", "half read", q, {16'd0, 8'h30 + 8'(s+1), 8'h30 + 8'(s)});
    s = p_bytes;
    bus(1'b0, 3'd3, 2'd2, 0, q, c);
    chk("R7", "offset 3 read one byte", q, {24'd0, 8'h30 + 8'(s)});
    chk("R6", "addr strobe on read", 32'(log_astb[s % 64]), 32'd1);
  endtask

  task automatic t_timeout;
    logic [31:0] q; int c, s;
    wreg(3'd2, 32'h04);
    resp_en = 1'b0;
    s = p_stb;
    bus(1'b1, 3'd4, 2'd2, 32'hCAFEF00D, q, c);
    chk("R8", "remaining bytes skipped", 32'(p_stb - s), 32'd1);
    chk("R8", "waited full limit", 32'(c >= TMO), 32'd1);
    chk("R8", "strobe released", {30'd0, n_dstb, n_astb}, 32'd3);
    bus(1'b0, 3'd1, 2'd0, 0, q, c);
    chk("R8", "flag set", q, 32'd1);
    wreg(3'd2, 32'h24);
    bus(1'b0, 3'd4, 2'd2, 0, q, c);
    chk("R8", "timed-out read ones", q, 32'hFFFFFFFF);
    resp_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_sticky;
    logic [31:0] q; int c;
    wreg(3'd2, 32'h04);
    wreg(3'd4, 32'h3C);
    bus(1'b0, 3'd1, 2'd0, 0, q, c);
    chk("R9", "sticky after good cycle", q, 32'd1);
    wreg(3'd1, 32'hFE);
    bus(1'b0, 3'd1, 2'd0, 0, q, c);
    chk("R9", "bit0 clear keeps flag", q, 32'd1);
    wreg(3'd1, 32'h01);
    bus(1'b0, 3'd1, 2'd0, 0, q, c);
    chk("R9", "bit0 set clears flag", q, 32'd0);
    chk("R2", "status upper bits zero", q & 32'hFFFFFFFE, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_wr_gate();
    t_writes();
    t_rd_gate();
    t_reads();
    t_timeout();
    t_sticky();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule